// File: doc/BRIEF.md
# Branch Source Trace Queue

This block keeps a short history of taken branches for debug. On every branch strobe it captures two things: the address fetched last before the branch, and a 3-bit pointer that counts the cycles from fetch to execution of the last executed instruction. It pushes the pair into an eight-deep shift queue with the valid flag set. The entry that falls off the far end of the queue is lost.

Software reads the history one 32-bit word at a time. Each read strobe returns the newest entry that has not been read yet and clears that entry's valid flag, so repeated reads walk back toward older branches. Once no valid entry is left, a read returns a word of zeros. Power-on reset and manual reset both clear every valid flag. Neither reset touches the stored address or pointer. Turning the pointer into a real source address, and decoding the bus address of the register, happen outside this block.

Top module: `bst_trace_queue`

## Requirements
- R1: The read word puts the valid flag in bit 31, the pointer in bits 30 to 28 and the 28-bit address in bits 27 to 0. It appears on `rd_data` in the cycle after the `rd_en` that requested it.
- R2: A cycle with `br_en` high stores `br_addr` and `br_ptr` as the newest entry, with its valid flag set to 1.
- R3: Each branch moves every stored entry one place older. After more than eight branches, only the eight newest stay readable, and the oldest ones are dropped.
- R4: A read returns the newest entry whose valid flag is 1, with bit 31 equal to 1, and clears that flag. The next read returns the next older valid entry.
- R5: A read made when no entry is valid returns 32'h0.
- R6: Asserting `por_rst` or `man_rst` clears every valid flag and sets `rd_data` to 0. Reads after the reset return 0 until a new branch arrives.
- R7: When `br_en` and `rd_en` are high in the same cycle, the read is served from the queue as it stood before the branch. The new entry is then pushed with its valid flag set.
- R8: In a cycle without `rd_en`, `rd_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| man_rst | input | 1 | Manual reset, synchronous, active high |
| br_en | input | 1 | Taken-branch strobe |
| br_addr | input | 28 | Last fetched address before the branch |
| br_ptr | input | 3 | Fetch-to-execute cycle pointer |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read word |

## Verification
The bench first fills the queue with eleven branches and then drains it. A design that failed to drop old entries, or that dropped the wrong one, would return stale addresses or a ninth valid word. It also reads past the last valid entry and expects zero, which catches a design that keeps returning old data. Cycles with a branch and a read together are checked against the queue state before the branch: a design that pushed first would hand back the new entry, or shift away the entry it had just cleared. A manual reset partway through must wipe every flag. A long pseudo-random mix of strobes is compared read by read against an arithmetic model of the queue.

// File: rtl/bst_pkg.sv
package bst_pkg;
    localparam int unsigned BST_ADDR_W = 28;
    localparam int unsigned BST_PTR_W  = 3;
    localparam int unsigned BST_WORD_W = 1 + BST_PTR_W + BST_ADDR_W;

    // Packed order fixes the software-visible layout: flag, pointer, address.
    typedef struct packed {
        logic                  vld;
        logic [BST_PTR_W-1:0]  ptr;
        logic [BST_ADDR_W-1:0] addr;
    } bst_entry_t;

    function automatic logic [BST_WORD_W-1:0] bst_to_word(input bst_entry_t e);
        return e;
    endfunction

    function automatic bst_entry_t bst_make(input logic [BST_PTR_W-1:0] p,
                                            input logic [BST_ADDR_W-1:0] a);
        bst_entry_t e;
        e.vld  = 1'b1;
        e.ptr  = p;
        e.addr = a;
        return e;
    endfunction
endpackage

// File: rtl/bst_pick.sv
module bst_pick
    import bst_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] vld,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    // Lowest index is the newest entry; it wins.
    always_comb begin
        idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (vld[i]) idx = IDX_W'(i);
        end
        hit = |vld;
    end
endmodule

// File: rtl/bst_store.sv
module bst_store
    import bst_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         flag_clr,
    input  logic                         push,
    input  logic [BST_PTR_W-1:0]         push_ptr,
    input  logic [BST_ADDR_W-1:0]        push_addr,
    input  logic                         clr_en,
    input  logic [IDX_W-1:0]             clr_idx,
    output bst_entry_t [DEPTH-1:0]       ent_q
);
    logic [DEPTH-1:0] vld_kept;

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        bst_entry_t stage_q;
        assign ent_q[i]    = stage_q;
        assign vld_kept[i] = stage_q.vld & ~(clr_en && (clr_idx == IDX_W'(i)));

        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (flag_clr) begin
                    stage_q.vld <= 1'b0;
                end else if (push) begin
                    stage_q <= bst_make(push_ptr, push_addr);
                end else begin
                    stage_q.vld <= vld_kept[0];
                end
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (flag_clr) begin
                    stage_q.vld <= 1'b0;
                end else if (push) begin
                    stage_q.vld  <= vld_kept[i-1];
                    stage_q.ptr  <= ent_q[i-1].ptr;
                    stage_q.addr <= ent_q[i-1].addr;
                end else begin
                    stage_q.vld <= vld_kept[i];
                end
            end

            // R3: each push moves the older payload one place along
            a_r3_shift_addr: assert property (@(posedge clk) disable iff (flag_clr)
                push |=> ent_q[i].addr == $past(ent_q[i-1].addr));
        end
    end

    // R2: a push lands in the newest slot, valid, with the captured fields
    a_r2_push_newest: assert property (@(posedge clk) disable iff (flag_clr)
        push |=> ent_q[0].vld && ent_q[0].ptr == $past(push_ptr)
                 && ent_q[0].addr == $past(push_addr));
endmodule

// File: rtl/bst_trace_queue.sv
module bst_trace_queue
    import bst_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        por_rst,
    input  logic        man_rst,
    input  logic        br_en,
    input  logic [27:0] br_addr,
    input  logic [2:0]  br_ptr,
    input  logic        rd_en,
    output logic [31:0] rd_data
);
    logic                   flag_clr;
    bst_entry_t [DEPTH-1:0] ent_q;
    logic [DEPTH-1:0]       vlds;
    logic                   hit;
    logic [IDX_W-1:0]       idx;
    logic [BST_WORD_W-1:0]  rd_q;

    assign flag_clr = por_rst | man_rst;

    for (genvar i = 0; i < DEPTH; i++) begin : g_vld
        assign vlds[i] = ent_q[i].vld;
    end

    bst_pick #(.DEPTH(DEPTH)) u_pick (
        .vld (vlds),
        .hit (hit),
        .idx (idx)
    );

    bst_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .flag_clr  (flag_clr),
        .push      (br_en),
        .push_ptr  (br_ptr),
        .push_addr (br_addr),
        .clr_en    (rd_en & hit),
        .clr_idx   (idx),
        .ent_q     (ent_q)
    );

    always_ff @(posedge clk) begin
        if (flag_clr) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= hit ? bst_to_word(ent_q[idx]) : '0;
        end
    end

    assign rd_data = rd_q;

    // R4: a read without a push removes exactly one valid flag
    a_r4_read_clears: assert property (@(posedge clk) disable iff (flag_clr)
        rd_en && hit && !br_en |=> $countones(vlds) == $countones($past(vlds)) - 1);

    // R4: a served read always reports a valid word
    a_r4_read_valid: assert property (@(posedge clk) disable iff (flag_clr)
        rd_en && hit |=> rd_data[31]);

    // R5: reading an empty queue yields zero
    a_r5_empty_zero: assert property (@(posedge clk) disable iff (flag_clr)
        rd_en && !hit |=> rd_data == '0);

    // R7: a push alongside a read still leaves a valid newest entry
    a_r7_push_wins_head: assert property (@(posedge clk) disable iff (flag_clr)
        rd_en && br_en |=> vlds[0]);

    // R8: no read, no change on the read port
    a_r8_hold: assert property (@(posedge clk) disable iff (flag_clr)
        !rd_en |=> $stable(rd_data));
endmodule

// File: tb/tb_bst_trace_queue.sv
`timescale 1ns/1ps
module tb_bst_trace_queue;
    logic        clk = 1'b0;
    logic        por_rst = 1'b1;
    logic        man_rst = 1'b0;
    logic        br_en = 1'b0;
    logic [27:0] br_addr = '0;
    logic [2:0]  br_ptr = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    logic        m_vld [8];
    logic [31:0] m_word [8];
    logic [31:0] m_rd = '0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #2.5 clk = ~clk;

    bst_trace_queue dut (
        .clk(clk), .por_rst(por_rst), .man_rst(man_rst),
        .br_en(br_en), .br_addr(br_addr), .br_ptr(br_ptr),
        .rd_en(rd_en), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: rd_data=%h expected=%h", req, act, exp);
        end
    endtask

    // Inputs change at a negedge; the result is sampled at the next negedge.
    task automatic step(input logic br, input logic [27:0] a, input logic [2:0] p,
                        input logic rd, input string req);
        br_en = br; br_addr = a; br_ptr = p; rd_en = rd;
        if (rd) begin
            m_rd = '0;
            for (int k = 7; k >= 0; k--) if (m_vld[k]) m_rd = m_word[k];
            for (int k = 0; k < 8; k++) if (m_vld[k]) begin m_vld[k] = 1'b0; break; end
        end
        if (br) begin
            for (int k = 7; k > 0; k--) begin m_vld[k] = m_vld[k-1]; m_word[k] = m_word[k-1]; end
            m_vld[0] = 1'b1;
            m_word[0] = {1'b1, p, a};
        end
        @(negedge clk);
        br_en = 1'b0; rd_en = 1'b0;
        if (rd) chk(req, rd_data, m_rd);
        else    chk("R8", rd_data, m_rd);
    endtask

    task automatic do_reset(input bit manual);
        if (manual) man_rst = 1'b1; else por_rst = 1'b1;
        @(negedge clk);
        por_rst = 1'b0; man_rst = 1'b0;
        for (int k = 0; k < 8; k++) m_vld[k] = 1'b0;
        m_rd = '0;
        chk("R6", rd_data, 32'h0);
    endtask

    function automatic logic [27:0] addr_of(input int n);
        return 28'(32'h0ABC_0000 + n * 32'h0001_0013);
    endfunction

    initial begin
        for (int k = 0; k < 8; k++) begin m_vld[k] = 1'b0; m_word[k] = '0; end
        @(negedge clk);
        @(negedge clk);
        do_reset(1'b0);
        step(0, '0, '0, 1, "R6");
        step(0, '0, '0, 1, "R5");

        // R2 / R4: three pushes come back newest first, then empty
        for (int n = 0; n < 3; n++) step(1, addr_of(n), 3'(n + 2), 0, "R2");
        for (int n = 0; n < 4; n++) step(0, '0, '0, 1, "R4");

        // R1: every pointer value, with distinct address patterns
        for (int n = 0; n < 8; n++) step(1, 28'hFFF_FFFF ^ addr_of(n * 7), 3'(n), 0, "R1");
        for (int n = 0; n < 9; n++) step(0, '0, '0, 1, "R1");

        // R3: eleven pushes, only the newest eight survive
        for (int n = 0; n < 11; n++) step(1, addr_of(100 + n), 3'(n), 0, "R3");
        for (int n = 0; n < 9; n++) step(0, '0, '0, 1, "R3");

        // R7: a read and a push in the same cycle
        step(1, 28'h1111111, 3'd1, 0, "R7");
        step(1, 28'h2222222, 3'd2, 0, "R7");
        step(1, 28'h3333333, 3'd3, 1, "R7");
        step(1, 28'h4444444, 3'd4, 1, "R7");
        for (int n = 0; n < 4; n++) step(0, '0, '0, 1, "R7");
        step(1, 28'h5555555, 3'd5, 1, "R7");
        step(0, '0, '0, 1, "R7");

        // R6: a manual reset wipes a full queue
        for (int n = 0; n < 8; n++) step(1, addr_of(200 + n), 3'(n), 0, "R6");
        step(0, '0, '0, 1, "R6");
        do_reset(1'b1);
        step(0, '0, '0, 1, "R6");

        // Mixed pseudo-random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            if (lfsr[7:0] == 8'h5A) do_reset(lfsr[8]);
            else step(lfsr[9] & lfsr[10], lfsr[27:0] ^ 28'(n), lfsr[13:11],
                      lfsr[14] | lfsr[15], "R4");
        end

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: rd_data=%h expected=completion", rd_data);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule